// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the instruction fetch unit and answers one question each cycle: where should fetch go next? The fetch address is presented on the lookup port. One clock later the block reports whether that address is a known branch (a hit in its target store), the taken/not-taken guess from a table of two-bit saturating counters, and the address to fetch next. On a miss or a not-taken guess the next address is the sequential one (fetch PC plus 4). On a hit with a taken guess it is the stored target.

When a branch resolves later in the pipeline, the pipeline reports the branch PC, the actual direction, the actual target and whether the earlier guess was wrong. The block then trains the counter for that PC. It allocates a target entry for a taken branch that is not yet stored, and it rewrites the stored target when a taken branch was mispredicted. Discarding wrong-path instructions, computing targets and generating flushes all belong to the surrounding pipeline.

Both tables are small register arrays. They are indexed by PC bits [IDX_W+1:2], and a target entry is tagged with PC bits [PC_W-1:IDX_W+2].

Top module: `fetch_steer_pred`

## Requirements
- R1: After reset every target entry is invalid and every counter holds 01 (weakly not-taken). A lookup then returns hit 0, taken 0 and next PC = PC+4. While reset is asserted the three lookup outputs read 0.
- R2: Lookup outputs are registered. A PC presented in cycle N produces its results after the clock edge that ends cycle N, and they reflect the table contents from before that edge.
- R3: Addresses are word aligned (bits 1:0 zero). The index is PC bits [IDX_W+1:2] and the tag is PC bits [PC_W-1:IDX_W+2]. A hit needs a valid entry whose tag matches, so a PC that shares an index but has a different tag misses. Such a PC still reads the shared counter.
- R4: The next PC equals the stored target only when hit and taken are both 1. Otherwise it equals the looked-up PC plus 4.
- R5: Counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. The taken guess is bit 1 of the counter. A resolved taken branch increments the counter and a resolved not-taken branch decrements it, saturating at 11 and at 00.
- R6: From a strong state, two consecutive opposite outcomes are needed to flip the guess. After a single opposite outcome the guess is unchanged.
- R7: A resolved taken branch that misses in the target store writes a valid entry holding its tag and target.
- R8: A resolved not-taken branch never allocates a target entry.
- R9: A resolved taken branch that hits rewrites the stored target only when the mispredict flag is 1. Without the flag the old target is kept.
- R10: While the update valid input is 0, the update inputs change neither table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Fetch address to look up |
| lk_hit | output | 1 | Registered: address found in target store |
| lk_taken | output | 1 | Registered: counter guess (1 = taken) |
| lk_next_pc | output | PC_W | Registered: predicted next fetch address |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual direction (1 = taken) |
| up_target | input | PC_W | Actual target of the branch |
| up_mispredict | input | 1 | Earlier guess for this branch was wrong |

## Verification
Every lookup result is due one clock edge after its PC is driven. The driver pushes the expected hit, taken and next-PC triple into a queue on the falling edge where it drives the PC. The monitor pops the triple shortly after the following rising edge and compares it there, so no lookup result is read early or late. An update takes effect at the rising edge after it is driven. The driver therefore issues the next lookup no earlier than the falling edge after that, and the bench's own table model is updated at the same point.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {
    CNT_SNT = 2'b00,
    CNT_WNT = 2'b01,
    CNT_WT  = 2'b10,
    CNT_STK = 2'b11
  } cnt_t;

  function automatic logic [1:0] cnt_step(input logic [1:0] cur, input logic tkn);
    logic [1:0] nxt;
    if (tkn) nxt = (cur == CNT_STK) ? cur : cur + 2'd1;
    else     nxt = (cur == CNT_SNT) ? cur : cur - 2'd1;
    return nxt;
  endfunction
endpackage

// File: rtl/fsp_dir_table.sv
module fsp_dir_table #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  import fsp_pkg::*;
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] cnt [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cnt[i] <= CNT_WNT;
    end else if (wr_en) begin
      cnt[wr_idx] <= cnt_step(cnt[wr_idx], wr_taken);
    end
  end

  assign rd_taken = cnt[rd_idx][1];

  // R1
  rst_weak_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt[0] == CNT_WNT));

  // R5
  sat_top_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && cnt[wr_idx] == CNT_STK) |=> (cnt[$past(wr_idx)] == CNT_STK));

  // R5
  sat_bot_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && cnt[wr_idx] == CNT_SNT) |=> (cnt[$past(wr_idx)] == CNT_SNT));

  // R10
  hold_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cnt[0]));
endmodule

// File: rtl/fsp_tgt_table.sv
module fsp_tgt_table #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [PC_W-1:0]  rd_tgt,
  input  logic [IDX_W-1:0] pr_idx,
  input  logic [TAG_W-1:0] pr_tag,
  output logic             pr_hit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt;
    end
  end

  assign rd_hit = vld[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_tgt = tgt_q[rd_idx];
  assign pr_hit = vld[pr_idx] && (tag_q[pr_idx] == pr_tag);

  // R7
  alloc_vld_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld[$past(wr_idx)]);

  // R7
  alloc_tag_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (tag_q[$past(wr_idx)] == $past(wr_tag)) && (tgt_q[$past(wr_idx)] == $past(wr_tgt)));

  // R1
  rst_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vld == '0));
endmodule

// File: rtl/fetch_steer_pred.sv
module fetch_steer_pred #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_next_pc,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target,
  input  logic            up_mispredict
);
  localparam int TAG_W = PC_W - IDX_W - 2;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             bt_hit, bt_probe_hit, dt_taken, bt_wr;
  logic [PC_W-1:0]  bt_tgt;

  assign lk_idx = lk_pc[IDX_W+1:2];
  assign lk_tag = lk_pc[PC_W-1:IDX_W+2];
  assign up_idx = up_pc[IDX_W+1:2];
  assign up_tag = up_pc[PC_W-1:IDX_W+2];

  assign bt_wr = up_valid && up_taken && (!bt_probe_hit || up_mispredict);

  fsp_dir_table #(.IDX_W(IDX_W)) u_dir (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (lk_idx),
    .rd_taken (dt_taken),
    .wr_en    (up_valid),
    .wr_idx   (up_idx),
    .wr_taken (up_taken)
  );

  fsp_tgt_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_tgt (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (lk_idx),
    .rd_tag (lk_tag),
    .rd_hit (bt_hit),
    .rd_tgt (bt_tgt),
    .pr_idx (up_idx),
    .pr_tag (up_tag),
    .pr_hit (bt_probe_hit),
    .wr_en  (bt_wr),
    .wr_idx (up_idx),
    .wr_tag (up_tag),
    .wr_tgt (up_target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit     <= 1'b0;
      lk_taken   <= 1'b0;
      lk_next_pc <= '0;
    end else begin
      lk_hit     <= bt_hit;
      lk_taken   <= dt_taken;
      lk_next_pc <= (bt_hit && dt_taken) ? bt_tgt : lk_pc + STEP;
    end
  end

  // R4
  seq_next_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !(lk_hit && lk_taken)) |-> (lk_next_pc == $past(lk_pc) + STEP));

  // R8
  no_alloc_nt_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_taken) |-> !bt_wr);

  // R3
  aligned_upd_chk: assert property (@(posedge clk) disable iff (rst)
    up_valid |-> (up_pc[1:0] == 2'b00));
endmodule

// File: tb/fetch_steer_pred_tb.sv
module fetch_steer_pred_tb;
  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int DEPTH = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst;
  logic [PC_W-1:0] lk_pc;
  logic            lk_hit, lk_taken;
  logic [PC_W-1:0] lk_next_pc;
  logic            up_valid, up_taken, up_mispredict;
  logic [PC_W-1:0] up_pc, up_target;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct packed {
    logic            hit;
    logic            tkn;
    logic [PC_W-1:0] npc;
  } exp_t;

  exp_t exp_q[$];
  string tag_q[$];

  logic            m_vld [DEPTH];
  logic [PC_W-1:0] m_tag [DEPTH];
  logic [PC_W-1:0] m_tgt [DEPTH];
  logic [1:0]      m_ctr [DEPTH];

  always #5 clk = ~clk;

  fetch_steer_pred #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_next_pc(lk_next_pc), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_target(up_target), .up_mispredict(up_mispredict)
  );

  function automatic int ix(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic [PC_W-1:0] tg(input logic [PC_W-1:0] pc);
    return pc >> (IDX_W + 2);
  endfunction

  task automatic check(input string req, input logic [PC_W+1:0] act, input logic [PC_W+1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input string req);
    exp_t e;
    int i;
    @(negedge clk);
    lk_pc = pc;
    i = ix(pc);
    e.hit = m_vld[i] && (m_tag[i] == tg(pc));
    e.tkn = m_ctr[i][1];
    e.npc = (e.hit && e.tkn) ? m_tgt[i] : pc + 32'd4;
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  task automatic upd(input logic v, input logic [PC_W-1:0] pc, input logic t,
                     input logic [PC_W-1:0] tgt, input logic mp);
    int i;
    logic h;
    @(negedge clk);
    up_valid = v; up_pc = pc; up_taken = t; up_target = tgt; up_mispredict = mp;
    if (v) begin
      i = ix(pc);
      h = m_vld[i] && (m_tag[i] == tg(pc));
      if (t && (!h || mp)) begin
        m_vld[i] = 1'b1; m_tag[i] = tg(pc); m_tgt[i] = tgt;
      end
      if (t) m_ctr[i] = (m_ctr[i] == 2'b11) ? 2'b11 : m_ctr[i] + 2'd1;
      else   m_ctr[i] = (m_ctr[i] == 2'b00) ? 2'b00 : m_ctr[i] - 2'd1;
    end
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      string r;
      e = exp_q.pop_front();
      r = tag_q.pop_front();
      check(r, {lk_hit, lk_taken, lk_next_pc}, e);
    end
  end

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 2'b01;
    end
    rst = 1'b1; lk_pc = 32'h0000_0100; up_valid = 1'b0; up_pc = '0;
    up_taken = 1'b0; up_target = '0; up_mispredict = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    check("R1 reset outputs", {lk_hit, lk_taken, lk_next_pc}, '0);
    rst = 1'b0;

    // R1 R2: empty tables after reset
    look(32'h0000_0100, "R1 empty lookup");
    look(32'h0000_003C, "R2 second lookup");

    // R7 R5: taken miss allocates, counter 01->10
    upd(1'b1, 32'h0000_0100, 1'b1, 32'h0000_0400, 1'b0);
    look(32'h0000_0100, "R7 allocated hit");
    look(32'h0000_0104, "R2 neighbour miss");
    // R3: same index, different tag
    look(32'h0000_0140, "R3 alias miss");

    // R4: not-taken mispredict, counter 10->01, hit but sequential
    upd(1'b1, 32'h0000_0100, 1'b0, 32'h0, 1'b1);
    look(32'h0000_0100, "R4 hit not-taken");

    // R6: drive to strong taken, then one wrong keeps taken, second flips
    upd(1'b1, 32'h0000_0100, 1'b1, 32'h0000_0400, 1'b1);
    upd(1'b1, 32'h0000_0100, 1'b1, 32'h0000_0400, 1'b0);
    look(32'h0000_0100, "R5 strong taken");
    upd(1'b1, 32'h0000_0100, 1'b0, 32'h0, 1'b1);
    look(32'h0000_0100, "R6 one wrong still taken");
    upd(1'b1, 32'h0000_0100, 1'b0, 32'h0, 1'b1);
    look(32'h0000_0100, "R6 two wrong flips");

    // R5: saturation at 00, one taken only reaches 01
    for (int k = 0; k < 3; k++) upd(1'b1, 32'h0000_0100, 1'b0, 32'h0, 1'b0);
    upd(1'b1, 32'h0000_0100, 1'b1, 32'h0000_0400, 1'b1);
    look(32'h0000_0100, "R5 low saturation");

    // R8: not-taken miss does not allocate
    upd(1'b1, 32'h0000_0208, 1'b0, 32'h0000_0AAC, 1'b0);
    look(32'h0000_0208, "R8 no allocate");

    // R9: taken mispredict on hit rewrites target
    upd(1'b1, 32'h0000_0100, 1'b1, 32'h0000_0800, 1'b1);
    look(32'h0000_0100, "R9 target rewritten");
    // R9: taken hit without flag keeps target
    upd(1'b1, 32'h0000_0100, 1'b1, 32'h0000_0900, 1'b0);
    look(32'h0000_0100, "R9 target kept");

    // R10: inactive update changes nothing
    upd(1'b0, 32'h0000_0100, 1'b0, 32'h0000_0C00, 1'b1);
    upd(1'b0, 32'h0000_0300, 1'b1, 32'h0000_0D00, 1'b1);
    look(32'h0000_0100, "R10 entry unchanged");
    look(32'h0000_0300, "R10 no allocate");

    // R7 R3: fill several indices, then sweep
    for (int k = 0; k < 6; k++)
      upd(1'b1, 32'h0001_0000 + 32'(k * 4), 1'b1, 32'h0002_0000 + 32'(k * 64), 1'b0);
    for (int k = 0; k < 6; k++) begin
      look(32'h0001_0000 + 32'(k * 4), "R7 sweep");
      look(32'h0003_0000 + 32'(k * 4), "R3 sweep alias");
    end

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule